// File: doc/BRIEF.md
# Interconnect Adapter Event Counter Bank

This block is a performance monitoring unit that sits beside a protocol adapter on an on-chip interconnect. It has eight 64-bit counters. Each counter picks one line of a 256-wide event pulse vector using an 8-bit code held in a select register. A counter adds one on every cycle in which its line pulses, but only while the global run bit and that counter's own enable bit are both set. Software reaches every register through a simple 32-bit write/read port. Each counter takes two 32-bit words: the low word at its base offset and the high word at base+4. Software can preload any counter by writing to it.

When a counter rolls over from all ones to zero, it sets a sticky status bit. The interrupt output is high while any status bit is set and its mask bit is 0. A build parameter picks one of two interrupt register layouts. In the default layout, status is cleared through its own write-1-to-clear register. In the alternate layout, software writes 1s straight into the status register to clear it.

Top module: `evctr_bank`

## Requirements
- R1: After reset, all counters, the run bit, the enable register, the select registers and the status register read 0. The mask register reads 0xFF and the interrupt output is low.
- R2: While run (bit 0 of 0x1C00) and enable bit n (register 0x1C04) are both 1, counter n adds exactly 1 on each cycle in which event line ev_pulse[code_n] is high. Counters whose selected lines pulse in the same cycle all advance.
- R3: With run at 0, or with enable bit n at 0, counter n holds its value while its event line pulses.
- R4: Event codes are 8 bits, four per 32-bit select word. Counters 0..3 use the word at 0x1C80 and counters 4..7 use the word at 0x1C84. Counter n uses bits [8*(n%4)+7 : 8*(n%4)] of its word, and the word reads back as written.
- R5: Counter n occupies 0x1D00+8*n (bits 31:0) and 0x1D04+8*n (bits 63:32). A write sets that half. A write and an event in the same cycle leave the written value, with no increment.
- R6: When counter n increments from all ones, it becomes 0 and status bit n sets. Status bit n stays set until software clears it, including through further counting.
- R7: The interrupt output is high exactly when some status bit n is 1 while mask bit n is 0. A mask bit of 1 blocks that counter's interrupt.
- R8: In the default layout (ALT_LAYOUT=0), the mask is at 0x1C70 and status is at 0x1C78, and writing status has no effect. Writing 1 to bit n of 0x1C7C clears status bit n.
- R9: In the alternate layout (ALT_LAYOUT=1), the mask is at 0x1C74 and status is at 0x1C70. Writing 1 to bit n of 0x1C70 clears status bit n.
- R10: 0x1CF0 returns the VERSION_ID parameter, and writes to it are ignored. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 13 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 13 | Register read byte offset |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| ev_pulse | input | 256 | Event pulse lines, indexed by event code |
| irq | output | 1 | Overflow interrupt, level |

## Verification
Counting is driven in four ways. A lone pulse on one counter's code shows that the code selects the right counter. Pulses on the code of a disabled counter, or with run cleared, separate the two gates. Pulses on two codes in the same cycle show that the counters advance independently. A write that lands in the same cycle as an event shows which one wins. Overflow is reached by preloading near all ones and stepping across the wrap. Across that wrap, the bench checks that status stays sticky, that the mask gates the interrupt, that status is read-only in the default layout, and that each layout's clear path works; the alternate layout is checked on a second instance.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int ADDR_W = 13;
  localparam int BUS_W  = 32;
  localparam int CTR_W  = 2 * BUS_W;

  localparam logic [ADDR_W-1:0] A_CTRL     = 13'h1C00;
  localparam logic [ADDR_W-1:0] A_ENA      = 13'h1C04;
  localparam logic [ADDR_W-1:0] A_MASK_DEF = 13'h1C70;
  localparam logic [ADDR_W-1:0] A_STAT_DEF = 13'h1C78;
  localparam logic [ADDR_W-1:0] A_CLR_DEF  = 13'h1C7C;
  localparam logic [ADDR_W-1:0] A_MASK_ALT = 13'h1C74;
  localparam logic [ADDR_W-1:0] A_STAT_ALT = 13'h1C70;
  localparam logic [ADDR_W-1:0] A_SEL0     = 13'h1C80;
  localparam logic [ADDR_W-1:0] A_VER      = 13'h1CF0;
  localparam logic [ADDR_W-1:0] A_CNT0     = 13'h1D00;
endpackage

// File: rtl/evb_rst_sync.sv
module evb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/evb_counter.sv
module evb_counter
  import evb_pkg::*;
#(
  parameter int CODE_W = 8,
  localparam int NUM_EV = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_ok,
  input  logic [CODE_W-1:0] code,
  input  logic [NUM_EV-1:0] ev_vec,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [CTR_W-1:0]  cnt,
  output logic              ovf
);
  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             inc;

  always_comb begin
    inc    = count_ok && ev_vec[code];
    cnt_ce = wr_lo || wr_hi || inc;
    cnt_d  = cnt_q;
    ovf    = 1'b0;
    if (wr_lo) begin
      cnt_d[BUS_W-1:0] = wr_data;
    end else if (wr_hi) begin
      cnt_d[CTR_W-1:BUS_W] = wr_data;
    end else if (inc) begin
      cnt_d = cnt_q + CTR_W'(1);
      ovf   = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/evb_ctrl_regs.sv
module evb_ctrl_regs
  import evb_pkg::*;
#(
  parameter int NUM_CTR    = 8,
  parameter int CODE_W     = 8,
  parameter bit ALT_LAYOUT = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [BUS_W-1:0]          wr_data,
  input  logic [NUM_CTR-1:0]        ovf,
  output logic                      run,
  output logic [NUM_CTR-1:0]        ctr_en,
  output logic [NUM_CTR*CODE_W-1:0] codes,
  output logic [NUM_CTR-1:0]        mask,
  output logic [NUM_CTR-1:0]        status,
  output logic [NUM_CTR-1:0]        clr
);
  localparam int CPR = BUS_W / CODE_W;
  localparam logic [ADDR_W-1:0] MASK_A = ALT_LAYOUT ? A_MASK_ALT : A_MASK_DEF;
  localparam logic [ADDR_W-1:0] CLR_A  = ALT_LAYOUT ? A_STAT_ALT : A_CLR_DEF;

  logic               run_q, run_ce;
  logic [NUM_CTR-1:0] en_q, mask_q, stat_q, stat_d;
  logic               en_ce, mask_ce, stat_ce;

  always_comb begin
    run_ce  = wr_en && (wr_addr == A_CTRL);
    en_ce   = wr_en && (wr_addr == A_ENA);
    mask_ce = wr_en && (wr_addr == MASK_A);
    clr     = (wr_en && (wr_addr == CLR_A)) ? wr_data[NUM_CTR-1:0] : '0;
    stat_d  = (stat_q & ~clr) | ovf;
    stat_ce = (|clr) || (|ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      en_q   <= '0;
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      if (run_ce)  run_q  <= wr_data[0];
      if (en_ce)   en_q   <= wr_data[NUM_CTR-1:0];
      if (mask_ce) mask_q <= wr_data[NUM_CTR-1:0];
      if (stat_ce) stat_q <= stat_d;
    end
  end

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_code
    localparam logic [ADDR_W-1:0] SEL_A = A_SEL0 + ADDR_W'(4 * (n / CPR));
    localparam int LSB = (n % CPR) * CODE_W;
    logic              code_ce;
    logic [CODE_W-1:0] code_q;

    assign code_ce = wr_en && (wr_addr == SEL_A);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       code_q <= '0;
      else if (code_ce) code_q <= wr_data[LSB +: CODE_W];
    end

    assign codes[n*CODE_W +: CODE_W] = code_q;
  end

  assign run    = run_q;
  assign ctr_en = en_q;
  assign mask   = mask_q;
  assign status = stat_q;
endmodule

// File: rtl/evctr_bank.sv
module evctr_bank
  import evb_pkg::*;
#(
  parameter int              NUM_CTR    = 8,
  parameter int              CODE_W     = 8,
  parameter bit              ALT_LAYOUT = 1'b0,
  parameter logic [BUS_W-1:0] VERSION_ID = 32'h5A00_0001
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [BUS_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [BUS_W-1:0]         rd_data,
  input  logic [(1<<CODE_W)-1:0]   ev_pulse,
  output logic                     irq
);
  localparam int CPR     = BUS_W / CODE_W;
  localparam int NUM_SEL = (NUM_CTR + CPR - 1) / CPR;
  localparam int SELW    = NUM_SEL * BUS_W;
  localparam logic [ADDR_W-1:0] MASK_A = ALT_LAYOUT ? A_MASK_ALT : A_MASK_DEF;
  localparam logic [ADDR_W-1:0] STAT_A = ALT_LAYOUT ? A_STAT_ALT : A_STAT_DEF;

  logic                      rst_sync_n;
  logic                      run_q;
  logic [NUM_CTR-1:0]        en_q, mask_q, status_q, clr_vec, ovf_vec;
  logic [NUM_CTR-1:0]        wr_lo_vec, wr_hi_vec;
  logic [NUM_CTR*CODE_W-1:0] codes;
  logic [SELW-1:0]           codes_pad;
  logic [NUM_CTR*CTR_W-1:0]  cnt_flat;

  evb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  evb_ctrl_regs #(
    .NUM_CTR    (NUM_CTR),
    .CODE_W     (CODE_W),
    .ALT_LAYOUT (ALT_LAYOUT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ovf     (ovf_vec),
    .run     (run_q),
    .ctr_en  (en_q),
    .codes   (codes),
    .mask    (mask_q),
    .status  (status_q),
    .clr     (clr_vec)
  );

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    localparam logic [ADDR_W-1:0] LO_A = A_CNT0 + ADDR_W'(8 * n);
    localparam logic [ADDR_W-1:0] HI_A = A_CNT0 + ADDR_W'(8 * n + 4);

    assign wr_lo_vec[n] = wr_en && (wr_addr == LO_A);
    assign wr_hi_vec[n] = wr_en && (wr_addr == HI_A);

    evb_counter #(
      .CODE_W (CODE_W)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .count_ok (run_q && en_q[n]),
      .code     (codes[n*CODE_W +: CODE_W]),
      .ev_vec   (ev_pulse),
      .wr_lo    (wr_lo_vec[n]),
      .wr_hi    (wr_hi_vec[n]),
      .wr_data  (wr_data),
      .cnt      (cnt_flat[n*CTR_W +: CTR_W]),
      .ovf      (ovf_vec[n])
    );
  end

  assign codes_pad = SELW'(codes);

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) rd_data = BUS_W'(run_q);
    if (rd_addr == A_ENA)  rd_data = BUS_W'(en_q);
    if (rd_addr == MASK_A) rd_data = BUS_W'(mask_q);
    if (rd_addr == STAT_A) rd_data = BUS_W'(status_q);
    if (rd_addr == A_VER)  rd_data = VERSION_ID;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (rd_addr == A_SEL0 + ADDR_W'(4 * k)) rd_data = codes_pad[k*BUS_W +: BUS_W];
    end
    for (int n = 0; n < NUM_CTR; n++) begin
      if (rd_addr == A_CNT0 + ADDR_W'(8 * n))
        rd_data = cnt_flat[n*CTR_W +: BUS_W];
      if (rd_addr == A_CNT0 + ADDR_W'(8 * n + 4))
        rd_data = cnt_flat[n*CTR_W + BUS_W +: BUS_W];
    end
  end

  assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/evb_checker.sv
module evb_checker #(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic [NUM_CTR-1:0] ovf,
  input logic [NUM_CTR-1:0] status,
  input logic [NUM_CTR-1:0] clr,
  input logic               irq,
  input logic [CTR_W-1:0]   cnt0,
  input logic               cnt0_wr
);
  // R2: without a write, counter 0 moves by at most one per cycle
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt0_wr |=> (cnt0 == $past(cnt0)) || (cnt0 == $past(cnt0) + CTR_W'(1)));

  // R3: a stopped bank never wraps
  a_r3_no_wrap_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (ovf == '0));

  // R6: a wrap sets its status bit on the next cycle
  a_r6_wrap_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf != '0) |=> ((status & $past(ovf)) == $past(ovf)));

  // R6: a set status bit only falls when cleared
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status != '0) |=> ((($past(status) & ~$past(clr)) & ~status) == '0));

  // R7: no interrupt without some pending status
  a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
endmodule

bind evctr_bank evb_checker #(
  .NUM_CTR (NUM_CTR),
  .CTR_W   (evb_pkg::CTR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .run     (run_q),
  .ovf     (ovf_vec),
  .status  (status_q),
  .clr     (clr_vec),
  .irq     (irq),
  .cnt0    (cnt_flat[evb_pkg::CTR_W-1:0]),
  .cnt0_wr (wr_lo_vec[0] || wr_hi_vec[0])
);

// File: tb/evctr_bank_bench.sv
module evctr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en_a, wr_en_b;
  logic [12:0] wr_addr, rd_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_a, rd_b;
  logic [255:0] ev;
  logic        irq_a, irq_b;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  evctr_bank u_evctr_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_a), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_a),
    .ev_pulse(ev), .irq(irq_a)
  );

  evctr_bank #(.ALT_LAYOUT(1'b1)) u_evctr_bank_alt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_b), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_b),
    .ev_pulse(ev), .irq(irq_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit alt, input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d;
    if (alt) wr_en_b = 1'b1; else wr_en_a = 1'b1;
    @(negedge clk);
    wr_en_a = 1'b0; wr_en_b = 1'b0;
  endtask

  task automatic rd(input bit alt, input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1;
    d = alt ? rd_b : rd_a;
  endtask

  task automatic rchk(input bit alt, input string req, input logic [12:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(alt, a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse(input int c0, input int c1);
    @(negedge clk);
    ev = '0;
    if (c0 >= 0) ev[c0] = 1'b1;
    if (c1 >= 0) ev[c1] = 1'b1;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic t_reset;
    rchk(0, "R1 run", 13'h1C00, 32'h0);
    rchk(0, "R1 enable", 13'h1C04, 32'h0);
    rchk(0, "R1 select", 13'h1C80, 32'h0);
    rchk(0, "R1 mask", 13'h1C70, 32'hFF);
    rchk(0, "R1 status", 13'h1C78, 32'h0);
    rchk(0, "R1 cnt0 lo", 13'h1D00, 32'h0);
    rchk(0, "R1 cnt7 hi", 13'h1D3C, 32'h0);
    chk("R1 irq", {31'h0, irq_a}, 32'h0);
  endtask

  task automatic t_version;
    rchk(0, "R10 version", 13'h1CF0, 32'h5A00_0001);
    wr(0, 13'h1CF0, 32'h1234_5678);
    rchk(0, "R10 version after write", 13'h1CF0, 32'h5A00_0001);
    rchk(0, "R10 unmapped", 13'h1C40, 32'h0);
  endtask

  task automatic t_select;
    wr(0, 13'h1C80, 32'h4433_2211);
    wr(0, 13'h1C84, 32'h8877_6655);
    rchk(0, "R4 select word0", 13'h1C80, 32'h4433_2211);
    rchk(0, "R4 select word1", 13'h1C84, 32'h8877_6655);
    wr(0, 13'h1C04, 32'h20);
    wr(0, 13'h1C00, 32'h1);
    pulse(8'h66, -1);
    rchk(0, "R4 counter5 uses code 0x66", 13'h1D28, 32'h1);
    rchk(0, "R4 counter6 untouched", 13'h1D30, 32'h0);
    pulse(8'h11, -1);
    rchk(0, "R3 disabled counter0 holds", 13'h1D00, 32'h0);
  endtask

  task automatic t_count;
    wr(0, 13'h1C04, 32'hFF);
    for (int i = 0; i < 3; i++) pulse(8'h11, -1);
    rchk(0, "R2 counter0 three pulses", 13'h1D00, 32'h3);
    pulse(8'h22, 8'h33);
    rchk(0, "R2 counter1 same cycle", 13'h1D08, 32'h1);
    rchk(0, "R2 counter2 same cycle", 13'h1D10, 32'h1);
    rchk(0, "R2 counter0 unaffected", 13'h1D00, 32'h3);
  endtask

  task automatic t_gating;
    wr(0, 13'h1C00, 32'h0);
    pulse(8'h11, -1);
    rchk(0, "R3 run clear holds", 13'h1D00, 32'h3);
    wr(0, 13'h1C00, 32'h1);
    wr(0, 13'h1C04, 32'hFE);
    pulse(8'h11, 8'h22);
    rchk(0, "R3 enable clear holds", 13'h1D00, 32'h3);
    rchk(0, "R2 enabled neighbour counts", 13'h1D08, 32'h2);
    wr(0, 13'h1C04, 32'hFF);
  endtask

  task automatic t_preload;
    wr(0, 13'h1D18, 32'h0000_1234);
    wr(0, 13'h1D1C, 32'h0000_ABCD);
    rchk(0, "R5 preload lo", 13'h1D18, 32'h0000_1234);
    rchk(0, "R5 preload hi", 13'h1D1C, 32'h0000_ABCD);
    @(negedge clk);
    wr_addr = 13'h1D18; wr_data = 32'h5; wr_en_a = 1'b1; ev[8'h44] = 1'b1;
    @(negedge clk);
    wr_en_a = 1'b0; ev = '0;
    rchk(0, "R5 write beats event", 13'h1D18, 32'h5);
    rchk(0, "R5 hi kept", 13'h1D1C, 32'h0000_ABCD);
  endtask

  task automatic t_overflow;
    wr(0, 13'h1D10, 32'hFFFF_FFFE);
    wr(0, 13'h1D14, 32'hFFFF_FFFF);
    pulse(8'h33, -1);
    rchk(0, "R6 at all ones", 13'h1D10, 32'hFFFF_FFFF);
    rchk(0, "R6 no status before wrap", 13'h1C78, 32'h0);
    pulse(8'h33, -1);
    rchk(0, "R6 wrapped lo", 13'h1D10, 32'h0);
    rchk(0, "R6 wrapped hi", 13'h1D14, 32'h0);
    rchk(0, "R6 status set", 13'h1C78, 32'h4);
    chk("R7 masked irq low", {31'h0, irq_a}, 32'h0);
    wr(0, 13'h1C78, 32'h4);
    rchk(0, "R8 status write ignored", 13'h1C78, 32'h4);
    wr(0, 13'h1C70, 32'hFB);
    @(negedge clk);
    chk("R7 unmasked irq high", {31'h0, irq_a}, 32'h1);
    pulse(8'h33, -1);
    rchk(0, "R6 status sticky", 13'h1C78, 32'h4);
    wr(0, 13'h1C7C, 32'h4);
    rchk(0, "R8 clear register", 13'h1C78, 32'h0);
    chk("R7 irq low after clear", {31'h0, irq_a}, 32'h0);
  endtask

  task automatic t_alt;
    rchk(1, "R9 alt mask reset", 13'h1C74, 32'hFF);
    rchk(1, "R9 alt status reset", 13'h1C70, 32'h0);
    wr(1, 13'h1C80, 32'h11);
    wr(1, 13'h1C04, 32'h1);
    wr(1, 13'h1C00, 32'h1);
    wr(1, 13'h1D00, 32'hFFFF_FFFF);
    wr(1, 13'h1D04, 32'hFFFF_FFFF);
    pulse(8'h11, -1);
    rchk(1, "R9 alt status set", 13'h1C70, 32'h1);
    chk("R9 alt irq masked", {31'h0, irq_b}, 32'h0);
    wr(1, 13'h1C74, 32'hFE);
    rchk(1, "R9 alt mask readback", 13'h1C74, 32'hFE);
    chk("R9 alt irq high", {31'h0, irq_b}, 32'h1);
    wr(1, 13'h1C70, 32'h1);
    rchk(1, "R9 alt status cleared", 13'h1C70, 32'h0);
    chk("R9 alt irq low", {31'h0, irq_b}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en_a = 1'b0; wr_en_b = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0; ev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_version();
    t_select();
    t_count();
    t_gating();
    t_preload();
    t_overflow();
    t_alt();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule